// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a processor's word load/store port and a memory port that moves whole 32-byte lines. It keeps 2048 entries. Each entry has a valid flag, a dirty flag, a 16-bit tag and one line of data. A 32-bit address is split into four fields. Tag is bits 31:16. Line index is bits 15:5 and picks the entry. Word select is bits 4:2 and picks one of the eight words in the line. Byte bits 1:0 are not used. A hit needs the indexed entry to be valid and its tag to match. On a hit, a load returns the word and a store merges its enabled bytes into the line. On a miss, the controller first writes back the old line if it is valid and modified. It then fetches the new line, installs it clean, and looks the request up again. Stores that miss therefore allocate the line and then merge as a hit.

The processor holds `cpu_req` with stable fields until `cpu_ready` pulses, then drops it. One request is in flight at a time. After reset, the valid flags are swept clear one entry per cycle, and no request is taken before the sweep ends.

The controller states are IDLE, COMPARE, WRITEBACK, REFILL and RESPOND. The transitions are:
- IDLE→COMPARE when a request arrives and the sweep is done.
- COMPARE→RESPOND on a hit.
- COMPARE→WRITEBACK on a miss whose victim is valid and dirty.
- COMPARE→REFILL on any other miss.
- WRITEBACK→REFILL on memory acknowledge.
- REFILL→COMPARE on memory acknowledge.
- RESPOND→IDLE always.

Top module: `dmc_cache`

## Requirements
- R1: During reset, `cpu_ready` and `mem_req` are low. After reset, no request is accepted, and no memory request is raised, for at least 2048 cycles while the valid flags are cleared.
- R2: A load that misses on an invalid or clean entry performs exactly one memory read at {TAG, LINE, 5'b0} with `mem_we` low. It performs no write and returns the word the memory holds.
- R3: A load that hits raises no memory request. It returns the cached word, and `cpu_ready` is seen in the second cycle after acceptance.
- R4: A store hit replaces byte lane i (bits 8i+7:8i) of the addressed word only where `cpu_be[i]` is 1. `cpu_rdata` shows the merged word, and the line becomes dirty.
- R5: A store miss first fetches the line, then merges the store into it (write-allocate). Later loads see the merged data.
- R6: A miss whose victim is valid and dirty writes the whole victim line to {old TAG, LINE, 5'b0} before the refill read is issued.
- R7: A miss whose victim is valid but clean issues no write.
- R8: Address bits 1:0 have no effect on which word is read or written.
- R9: `cpu_ready` is high for exactly one cycle per request, with `cpu_rdata` valid in that cycle.
- R10: Right after the clearing sweep every access misses, including accesses whose tag is zero.
- R11: `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ack`, and `mem_addr[4:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables, bit i = byte lane i |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Loaded word, or the merged word for a store |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 256 | Line written back |
| mem_rline | input | 256 | Line returned, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
Each fault in the lookup state shows up on the ports as wrong memory traffic. A lost dirty flag drops the write-back when the line is next evicted. A stale valid flag or tag turns a miss into a hit with no read, so a wrong word comes back at once. A merge fault in a store is visible immediately in `cpu_rdata` on the ready pulse. A fault in the stored line is visible either at the next load of that word or in the line written back on eviction. The reference model therefore predicts, for every access, the number of reads and writes, the write-back address and contents, and the returned word. Most faults are then caught on the first access that touches the affected entry.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COMPARE   = 3'd1,
        ST_WRITEBACK = 3'd2,
        ST_REFILL    = 3'd3,
        ST_RESPOND   = 3'd4
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 11,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    output logic             clr_busy
);
    localparam int LINES = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    logic             valid_mem [LINES];
    logic             dirty_mem [LINES];
    logic [TAG_W-1:0] tag_mem   [LINES];
    logic             clr_q;
    logic [IDX_W-1:0] clr_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q     <= 1'b1;
            clr_idx_q <= '0;
        end else if (clr_q) begin
            clr_idx_q <= clr_idx_q + 1'b1;
            if (clr_idx_q == LAST_IDX) clr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr_q) begin
            valid_mem[clr_idx_q] <= 1'b0;
            dirty_mem[clr_idx_q] <= 1'b0;
        end else if (wr_en) begin
            valid_mem[idx] <= wr_valid;
            dirty_mem[idx] <= wr_dirty;
            tag_mem[idx]   <= wr_tag;
        end
    end

    assign rd_valid = valid_mem[idx];
    assign rd_dirty = dirty_mem[idx];
    assign rd_tag   = tag_mem[idx];
    assign clr_busy = clr_q;

    // R1: the sweep ends after its last entry and the controller never writes during it
    assert_clear_finish_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && clr_idx_q == LAST_IDX) |=> !clr_q);
    assert_no_write_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> !wr_en);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 11,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_W-1:0] line_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) line_mem[idx] <= wr_line;
    end

    assign rd_line = line_mem[idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 11,
    parameter int OFF_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_busy,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [DATA_W-1:0]      cpu_wdata,
    input  logic [DATA_W/8-1:0]    cpu_be,
    output logic                   cpu_ready,
    output logic [DATA_W-1:0]      cpu_rdata,
    output logic [IDX_W-1:0]       lk_idx,
    input  logic                   lk_valid,
    input  logic                   lk_dirty,
    input  logic [TAG_W-1:0]       lk_tag,
    input  logic [(8<<OFF_W)-1:0]  lk_line,
    output logic                   tw_en,
    output logic [TAG_W-1:0]       tw_tag,
    output logic                   tw_valid,
    output logic                   tw_dirty,
    output logic                   dw_en,
    output logic [(8<<OFF_W)-1:0]  dw_line,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [(8<<OFF_W)-1:0]  mem_wline,
    input  logic [(8<<OFF_W)-1:0]  mem_rline,
    input  logic                   mem_ack
);
    localparam int LINE_W = 8 << OFF_W;
    localparam int BYTES  = DATA_W / 8;
    localparam int BSEL_W = $clog2(BYTES);
    localparam int WSEL_W = OFF_W - BSEL_W;
    localparam int WORDS  = 1 << WSEL_W;

    dmc_state_e state_q, state_d;

    logic              rq_we;
    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [WSEL_W-1:0] rq_word;
    logic [DATA_W-1:0] rq_wdata;
    logic [BYTES-1:0]  rq_be;
    logic [DATA_W-1:0] rdata_q;

    logic              hit;
    logic [LINE_W-1:0] merged_line;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] new_word;
    logic              unused_byte_sel;

    assign unused_byte_sel = ^cpu_addr[BSEL_W-1:0];

    assign lk_idx   = rq_idx;
    assign hit      = lk_valid && (lk_tag == rq_tag);
    assign cur_word = lk_line[rq_word*DATA_W +: DATA_W];
    assign new_word = merged_line[rq_word*DATA_W +: DATA_W];

    // byte-lane merge of the pending store into the looked-up line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign merged_line[w*DATA_W + b*8 +: 8] =
                (rq_we && rq_word == WSEL_W'(w) && rq_be[b])
                    ? rq_wdata[b*8 +: 8]
                    : lk_line[w*DATA_W + b*8 +: 8];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (!clr_busy && cpu_req) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (hit)                        state_d = ST_RESPOND;
                else if (lk_valid && lk_dirty)  state_d = ST_WRITEBACK;
                else                            state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
            ST_REFILL:    if (mem_ack) state_d = ST_COMPARE;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // request capture and response word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we    <= 1'b0;
            rq_tag   <= '0;
            rq_idx   <= '0;
            rq_word  <= '0;
            rq_wdata <= '0;
            rq_be    <= '0;
            rdata_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && !clr_busy && cpu_req) begin
                rq_we    <= cpu_we;
                rq_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
                rq_idx   <= cpu_addr[OFF_W +: IDX_W];
                rq_word  <= cpu_addr[BSEL_W +: WSEL_W];
                rq_wdata <= cpu_wdata;
                rq_be    <= cpu_be;
            end
            if (state_q == ST_COMPARE && hit)
                rdata_q <= rq_we ? new_word : cur_word;
        end
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        tw_en     = 1'b0;
        tw_tag    = rq_tag;
        tw_valid  = 1'b1;
        tw_dirty  = 1'b0;
        dw_en     = 1'b0;
        dw_line   = merged_line;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {rq_tag, rq_idx, {OFF_W{1'b0}}};
        mem_wline = lk_line;
        unique case (state_q)
            ST_IDLE: ;
            ST_COMPARE: begin
                if (hit && rq_we) begin
                    dw_en    = 1'b1;
                    tw_en    = 1'b1;
                    tw_dirty = 1'b1;
                end
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {lk_tag, rq_idx, {OFF_W{1'b0}}};
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    dw_en   = 1'b1;
                    dw_line = mem_rline;
                    tw_en   = 1'b1;
                end
            end
            ST_RESPOND: cpu_ready = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // R1: nothing leaves IDLE while the sweep runs
    assert_hold_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> (state_q == ST_IDLE && !mem_req));
    // R9: the completion pulse lasts one cycle
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R11: memory request stays put until acknowledged
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
    assert_line_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));
    // R6: a write-back never targets the line being fetched
    assert_wb_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[ADDR_W-1 -: TAG_W] != rq_tag));
    // R5: after a refill the entry holds the requested tag
    assert_refill_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL && mem_ack) |=> (state_q == ST_COMPARE && lk_valid && lk_tag == rq_tag && !lk_dirty));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 11,
    parameter int OFF_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [DATA_W/8-1:0]   cpu_be,
    output logic                  cpu_ready,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [(8<<OFF_W)-1:0] mem_wline,
    input  logic [(8<<OFF_W)-1:0] mem_rline,
    input  logic                  mem_ack
);
    localparam int LINE_W = 8 << OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid, lk_dirty;
    logic [TAG_W-1:0]  lk_tag;
    logic [LINE_W-1:0] lk_line;
    logic              tw_en, tw_valid, tw_dirty;
    logic [TAG_W-1:0]  tw_tag;
    logic              dw_en;
    logic [LINE_W-1:0] dw_line;
    logic              clr_busy;

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(lk_idx),
        .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_tag(lk_tag),
        .wr_en(tw_en), .wr_tag(tw_tag), .wr_valid(tw_valid), .wr_dirty(tw_dirty),
        .clr_busy(clr_busy)
    );

    dmc_data_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
        .clk(clk), .idx(lk_idx), .rd_line(lk_line),
        .wr_en(dw_en), .wr_line(dw_line)
    );

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_busy(clr_busy),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
        .lk_tag(lk_tag), .lk_line(lk_line),
        .tw_en(tw_en), .tw_tag(tw_tag), .tw_valid(tw_valid), .tw_dirty(tw_dirty),
        .dw_en(dw_en), .dw_line(dw_line),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
    );
endmodule

// File: tb/dmc_cache_bench.sv
`timescale 1ns/1ps
module dmc_cache_bench;
    localparam int LINES = 2048;
    localparam int LAT   = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [255:0] mem_wline;
    logic [255:0] mem_rline = '0;
    logic         mem_ack = 1'b0;

    dmc_cache u_dmc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // memory image and expected contents
    logic [255:0] mem_img [logic [26:0]];
    logic [31:0]  gold    [logic [29:0]];
    // reference lookup state per index
    bit           r_valid [int];
    bit           r_dirty [int];
    logic [15:0]  r_tag   [int];

    // traffic seen during one access
    int           n_rd, n_wr;
    logic [31:0]  wb_addr;
    bit           first_is_wr;

    function automatic logic [31:0] pat(logic [29:0] wa);
        return (32'h9E37_79B9 * {2'b00, wa}) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] gold_word(logic [29:0] wa);
        return gold.exists(wa) ? gold[wa] : pat(wa);
    endfunction

    function automatic logic [255:0] gold_line(logic [26:0] la);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = gold_word({la, 3'(i)});
        return l;
    endfunction

    function automatic logic [255:0] mem_line(logic [26:0] la);
        logic [255:0] l;
        if (mem_img.exists(la)) return mem_img[la];
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = pat({la, 3'(i)});
        return l;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                logic        we0;
                logic [31:0] a0;
                logic [255:0] wl0;
                we0 = mem_we;
                a0  = mem_addr;
                wl0 = mem_wline;
                if (n_rd + n_wr == 0) first_is_wr = we0;
                check(a0[4:0] == 5'd0, "R11", "line alignment", 64'(a0), 64'(a0 & ~32'h1F));
                repeat (LAT) @(negedge clk);
                check(mem_req && mem_we == we0 && mem_addr == a0, "R11", "request hold",
                      64'({mem_req, mem_we, mem_addr}), 64'({1'b1, we0, a0}));
                if (we0) begin
                    n_wr++;
                    wb_addr = a0;
                    check(wl0 == gold_line(a0[31:5]), "R6", "write-back line low word",
                          64'(wl0[63:0]), 64'(gold_line(a0[31:5]) >> 0));
                    mem_img[a0[31:5]] = wl0;
                end else begin
                    n_rd++;
                    mem_rline = mem_line(a0[31:5]);
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // one access with full reference prediction
    task automatic access(bit we, logic [31:0] addr, logic [31:0] wd, logic [3:0] be, string req);
        int idx;
        logic [15:0] tg;
        bit hit, exp_wb;
        logic [31:0] exp_wb_addr, exp_data;
        int cyc;
        idx = int'(addr[15:5]);
        tg  = addr[31:16];
        hit = r_valid.exists(idx) && r_valid[idx] && r_tag[idx] == tg;
        exp_wb = !hit && r_valid.exists(idx) && r_valid[idx] && r_dirty[idx];
        exp_wb_addr = exp_wb ? {r_tag[idx], addr[15:5], 5'd0} : 32'd0;
        exp_data = we ? merge(gold_word(addr[31:2]), wd, be) : gold_word(addr[31:2]);
        n_rd = 0; n_wr = 0; wb_addr = '0; first_is_wr = 0;
        cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be; cpu_req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 400 && !done);
        cpu_req = 1'b0;
        check(cpu_ready == 1'b1, req, "ready seen", 64'(cpu_ready), 64'd1);
        check(cpu_rdata == exp_data, req, "data", 64'(cpu_rdata), 64'(exp_data));
        check(n_rd == (hit ? 0 : 1), req, "read count", 64'(n_rd), 64'(hit ? 0 : 1));
        check(n_wr == (exp_wb ? 1 : 0), req, "write count", 64'(n_wr), 64'(exp_wb ? 1 : 0));
        if (exp_wb) begin
            check(wb_addr == exp_wb_addr, "R6", "write-back address", 64'(wb_addr), 64'(exp_wb_addr));
            check(first_is_wr == 1'b1, "R6", "write-back precedes refill", 64'(first_is_wr), 64'd1);
        end
        if (hit) check(cyc == 2, "R3", "hit latency", 64'(cyc), 64'd2);
        @(negedge clk);
        check(cpu_ready == 1'b0, "R9", "ready single pulse", 64'(cpu_ready), 64'd0);
        if (we) gold[addr[31:2]] = exp_data;
        if (!hit) begin
            r_valid[idx] = 1; r_tag[idx] = tg; r_dirty[idx] = 0;
        end
        if (we) r_dirty[idx] = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(cpu_ready == 0 && mem_req == 0, "R1", "reset outputs", 64'({cpu_ready, mem_req}), 64'd0);
        rst_n = 1'b1;
        // R1/R10: request held from the start waits for the sweep, then misses on tag 0
        cpu_we = 0; cpu_addr = 32'h0000_0004; cpu_be = 4'hF; cpu_req = 1'b1;
        n_rd = 0; n_wr = 0; cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc < LINES)
                check(!cpu_ready && !mem_req, "R1", "idle during clear",
                      64'({cpu_ready, mem_req}), 64'd0);
        end while (!cpu_ready && cyc < 5000);
        cpu_req = 1'b0;
        check(cyc > LINES, "R1", "clear duration", 64'(cyc), 64'(LINES + 1));
        check(n_rd == 1, "R10", "tag-zero first access misses", 64'(n_rd), 64'd1);
        check(cpu_rdata == pat(30'd1), "R2", "miss data", 64'(cpu_rdata), 64'(pat(30'd1)));
        r_valid[0] = 1; r_tag[0] = 16'h0; r_dirty[0] = 0;
        @(negedge clk);

        access(0, 32'h0000_0004, '0, 4'h0, "R3");                 // hit
        access(0, 32'h0000_0007, '0, 4'h0, "R8");                 // byte bits ignored
        access(0, 32'h0001_0024, '0, 4'h0, "R2");                 // clean miss, other line
        access(1, 32'h0000_0008, 32'hA1B2_C3D4, 4'b0101, "R4");   // store hit
        access(0, 32'h0000_000B, '0, 4'h0, "R4");                 // read back, byte bits set
        access(0, 32'h0002_0000, '0, 4'h0, "R6");                 // dirty victim eviction
        access(0, 32'h0000_0008, '0, 4'h0, "R6");                 // data survived eviction
        access(0, 32'h0003_0000, '0, 4'h0, "R7");                 // clean victim, no write
        access(1, 32'h0004_0040, 32'hDEAD_BEEF, 4'b1110, "R5");   // store miss allocate
        access(0, 32'h0004_0041, '0, 4'h0, "R5");                 // read merged back
        access(1, 32'h0005_0040, 32'h1234_5678, 4'b1111, "R6");   // evicts dirty allocate line
        access(0, 32'h0004_0040, '0, 4'h0, "R5");

        for (int i = 0; i < 400 && !done; i++) begin
            logic [31:0] a;
            a = {16'($urandom_range(0, 3)), 11'($urandom_range(0, 7)),
                 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            access(1'($urandom_range(0, 1)), a, $urandom, 4'($urandom_range(0, 15)), "R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule